// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend Sequencer

This block sits on the controller side of a single-data-rate SDRAM port and owns the clock-enable pin during data bursts. A burst request arrives on a valid/ready stream. The block counts the burst's column cycles and delays read beats through a capture pipeline as deep as the CAS latency. While a burst is in flight, a user-side suspend request pulls clock enable low. The beat counter and the capture pipeline then stand still, so the burst resumes at the beat where it stopped.

When the request drops, clock enable returns high and new bursts stay blocked for a recovery window. The device does no refresh while suspended, so a counter limits how long clock enable may stay low. If the user still holds the request at that limit, the block forces an exit, raises a timeout flag and ignores the request until the burst has drained.

Stream rules: a burst is taken in a cycle where `burst_valid` and `burst_ready` are both high. `burst_ready` is low whenever a burst or its read tail is in progress, while clock enable is low, and during recovery. A requester that sees `burst_ready` low must hold `burst_valid` and `burst_write` steady until the handshake completes.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: During reset and in the first cycle after reset, `sdram_cke` is 1, `burst_ready` is 1, and `beat_en`, `rd_capture` and `timeout_flag` are 0.
- R2: After a burst is accepted with no suspend, `beat_en` is high for exactly BL consecutive cycles, starting in the cycle after the handshake.
- R3: For a read burst (`burst_write`=0), `rd_capture` is high in exactly BL cycles. With no suspend, the first of these cycles comes CL cycles after the first `beat_en` cycle. A write burst (`burst_write`=1) produces no capture.
- R4: When no burst is in flight, `susp_req` is ignored and `sdram_cke` stays 1.
- R5: If `susp_req` is high in a cycle while a burst is in flight, `sdram_cke` is 0 in the next cycle. It stays 0 for as long as the request is held, up to the limit in R9.
- R6: While `sdram_cke` is 0, `beat_en` and `rd_capture` are 0. The burst keeps its position, so the total number of beats and captures is still BL, and the end of the burst moves later by the number of suspended cycles.
- R7: If `susp_req` is low in a cycle where `sdram_cke` is 0, `sdram_cke` is 1 in the next cycle.
- R8: `burst_ready` stays low for the TCKA cycles that begin with the cycle in which `sdram_cke` returns to 1.
- R9: `sdram_cke` never stays 0 for more than SUSP_MAX consecutive cycles. If `susp_req` is still high in the SUSP_MAX-th low cycle, `sdram_cke` returns to 1 and `timeout_flag` rises in the next cycle. `sdram_cke` then stays 1 until the burst has finished, even if the request is held.
- R10: `timeout_flag` clears in the cycle after the first cycle in which no burst is in flight.
- R11: If `susp_req` drops in the SUSP_MAX-th low cycle itself, the exit is an ordinary one and `timeout_flag` stays 0.
- R12: `burst_ready` is 0 from the cycle after a handshake until the burst, including its read tail, is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_valid | input | 1 | A burst request is offered |
| burst_write | input | 1 | Direction of the offered burst: 1 write, 0 read |
| burst_ready | output | 1 | Burst can be accepted this cycle |
| susp_req | input | 1 | User request to suspend the device clock |
| sdram_cke | output | 1 | Clock enable driven to the SDRAM |
| beat_en | output | 1 | A column beat of the burst advances this cycle |
| rd_capture | output | 1 | Sample read data from the device this cycle |
| timeout_flag | output | 1 | Suspend was cut short by the refresh guard |

## Verification
Two functions can act in the same cycle: the user's release of the suspend request and the refresh guard's forced exit. Both happen in the SUSP_MAX-th low cycle of clock enable. The bench builds this case by dropping the request in exactly that cycle, and builds a second case that holds the request one cycle longer. In both cases clock enable is low for exactly SUSP_MAX cycles. The first case must leave the timeout flag clear, and the second must raise it and keep clock enable high while the request is still held.

// File: rtl/cke_susp_pkg.sv
package cke_susp_pkg;
  // Direction carried by a burst request.
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } burst_dir_e;

  // Counter width able to hold values 0..max_val, never below one bit.
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/cke_susp_seq.sv
module cke_susp_seq
  import cke_susp_pkg::*;
#(
  parameter int TCKA     = 2,
  parameter int SUSP_MAX = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic susp_req,
  output logic cke,
  output logic lock,
  output logic recovering
);
  localparam int SW = cnt_width(SUSP_MAX);
  localparam int RW = cnt_width(TCKA);

  logic [SW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic          at_limit;
  logic          cke_nxt;

  // Last allowed low cycle before refresh must be given room.
  assign at_limit = !cke && (low_cnt == SW'(SUSP_MAX - 1));

  always_comb begin
    if (!cke) cke_nxt = !(susp_req && !at_limit);
    else      cke_nxt = !(busy && susp_req && !lock);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke     <= 1'b1;
      low_cnt <= '0;
      lock    <= 1'b0;
      rec_cnt <= '0;
    end else begin
      cke <= cke_nxt;

      if (cke) low_cnt <= '0;
      else     low_cnt <= low_cnt + SW'(1);

      if (!cke && susp_req && at_limit) lock <= 1'b1;
      else if (!busy)                   lock <= 1'b0;

      if (!cke && cke_nxt)    rec_cnt <= RW'(TCKA);
      else if (rec_cnt != '0) rec_cnt <= rec_cnt - RW'(1);
    end
  end

  assign recovering = (rec_cnt != '0);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import cke_susp_pkg::*;
#(
  parameter int BL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  input  logic run,
  output logic beat_en,
  output logic rd_beat,
  output logic active
);
  localparam int BW = cnt_width(BL);

  logic [BW-1:0] left;
  burst_dir_e    dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      dir  <= DIR_READ;
    end else if (start) begin
      left <= BW'(BL);
      dir  <= start_wr ? DIR_WRITE : DIR_READ;
    end else if (run && left != '0) begin
      left <= left - BW'(1);
    end
  end

  assign active  = (left != '0);
  assign beat_en = run && active;
  assign rd_beat = beat_en && (dir == DIR_READ);
endmodule

// File: rtl/rd_capture_pipe.sv
module rd_capture_pipe #(
  parameter int CL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_beat,
  input  logic run,
  output logic capture,
  output logic pending
);
  logic [CL-1:0] stage;

  // Stages advance only on cycles where the device clock runs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (run) begin
      stage[0] <= rd_beat;
      for (int k = 1; k < CL; k++) stage[k] <= stage[k-1];
    end
  end

  assign capture = run && stage[CL-1];
  assign pending = |stage;
endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl #(
  parameter int CL       = 2,
  parameter int BL       = 4,
  parameter int TCKA     = 2,
  parameter int SUSP_MAX = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_valid,
  input  logic burst_write,
  output logic burst_ready,
  input  logic susp_req,
  output logic sdram_cke,
  output logic beat_en,
  output logic rd_capture,
  output logic timeout_flag
);
  logic busy, beat_active, tail_pending, recovering, rd_beat, start;

  assign busy        = beat_active || tail_pending;
  assign burst_ready = !busy && sdram_cke && !recovering;
  assign start       = burst_valid && burst_ready;

  cke_susp_seq #(.TCKA(TCKA), .SUSP_MAX(SUSP_MAX)) i_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .susp_req(susp_req),
    .cke(sdram_cke), .lock(timeout_flag), .recovering(recovering)
  );

  burst_beat_ctr #(.BL(BL)) i_beats (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(burst_write),
    .run(sdram_cke), .beat_en(beat_en), .rd_beat(rd_beat),
    .active(beat_active)
  );

  rd_capture_pipe #(.CL(CL)) i_pipe (
    .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .run(sdram_cke),
    .capture(rd_capture), .pending(tail_pending)
  );
endmodule

// File: rtl/cke_suspend_chk.sv
module cke_suspend_chk #(
  parameter int SUSP_MAX = 1200
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic susp_req,
  input logic burst_ready,
  input logic sdram_cke,
  input logic beat_en,
  input logic rd_capture,
  input logic timeout_flag
);
  int low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         low_run <= 0;
    else if (sdram_cke) low_run <= 0;
    else                low_run <= low_run + 1;
  end

  AST_IDLE_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (sdram_cke && !busy) |=> sdram_cke); // R4
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sdram_cke |-> (!beat_en && !rd_capture)); // R6
  AST_RELEASE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdram_cke && !susp_req) |=> sdram_cke); // R7
  AST_RECOVERY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdram_cke) |-> !burst_ready); // R8
  AST_SUSP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !sdram_cke |-> (low_run < SUSP_MAX)); // R9
  AST_LOCK_KEEPS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> sdram_cke); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ready |-> !busy); // R12
endmodule

bind cke_suspend_ctrl cke_suspend_chk #(.SUSP_MAX(SUSP_MAX)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .susp_req(susp_req),
  .burst_ready(burst_ready), .sdram_cke(sdram_cke), .beat_en(beat_en),
  .rd_capture(rd_capture), .timeout_flag(timeout_flag)
);

// File: tb/test_cke_suspend_ctrl.sv
`timescale 1ns/1ps
module test_cke_suspend_ctrl;
  localparam int CL = 2, BL = 4, TCKA = 3, SMAX = 6;
  localparam int NCYC = 32;
  localparam int NVEC = 6;
  // dir(1=write), suspend start cycle, suspend length, ready cycle, captures, beats
  localparam int VEC [NVEC][6] = '{
    '{0, 0, 0,  7, 4, 4},
    '{1, 0, 0,  5, 0, 4},
    '{0, 2, 3, 10, 4, 4},
    '{0, 5, 2, 11, 4, 4},
    '{1, 1, 4,  9, 0, 4},
    '{1, 3, 1,  8, 0, 4}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, burst_valid, burst_write, burst_ready, susp_req;
  logic sdram_cke, beat_en, rd_capture, timeout_flag;

  cke_suspend_ctrl #(.CL(CL), .BL(BL), .TCKA(TCKA), .SUSP_MAX(SMAX)) i_cke_suspend_ctrl (
    .clk(clk), .rst_n(rst_n), .burst_valid(burst_valid), .burst_write(burst_write),
    .burst_ready(burst_ready), .susp_req(susp_req), .sdram_cke(sdram_cke),
    .beat_en(beat_en), .rd_capture(rd_capture), .timeout_flag(timeout_flag)
  );

  int n_chk = 0, n_fail = 0;
  logic cke_t [NCYC], flg_t [NCYC], rdy_t [NCYC], bt_t [NCYC], cap_t [NCYC];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Offer one burst in cycle 0; hold susp_req in cycles s..s+len-1.
  task automatic run_burst(input int wr, input int s, input int len);
    @(negedge clk);
    burst_valid = 1'b1;
    burst_write = wr[0];
    check("R12 ready before handshake", int'(burst_ready), 1);
    for (int i = 1; i < NCYC; i++) begin
      @(negedge clk);
      burst_valid = 1'b0;
      susp_req    = (len > 0) && (i >= s) && (i < s + len);
      cke_t[i] = sdram_cke;  flg_t[i] = timeout_flag; rdy_t[i] = burst_ready;
      bt_t[i]  = beat_en;    cap_t[i] = rd_capture;
    end
    susp_req = 1'b0;
  endtask

  function automatic int first_ready();
    for (int i = 1; i < NCYC; i++) if (rdy_t[i]) return i;
    return -1;
  endfunction

  function automatic int count(input int which);
    int n = 0;
    for (int i = 1; i < NCYC; i++) begin
      case (which)
        0: n += int'(bt_t[i]);
        1: n += int'(cap_t[i]);
        default: n += int'(!cke_t[i]);
      endcase
    end
    return n;
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; burst_valid = 1'b0; burst_write = 1'b0; susp_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cke in reset", int'(sdram_cke), 1);
    check("R1 ready in reset", int'(burst_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 beat after reset", int'(beat_en), 0);
    check("R1 capture after reset", int'(rd_capture), 0);
    check("R1 flag after reset", int'(timeout_flag), 0);

    // R4: request while idle has no effect
    susp_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 cke idle", int'(sdram_cke), 1);
    end
    susp_req = 1'b0;
    @(negedge clk);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      run_burst(VEC[v][0], VEC[v][1], VEC[v][2]);
      check("R8 R12 ready cycle", first_ready(), VEC[v][3]);
      check("R3 R6 captures", count(1), VEC[v][4]);
      check("R2 R6 beats", count(0), VEC[v][5]);
      check("R5 low cycles", count(2), VEC[v][2]);
      if (v == 0) begin
        check("R2 beat first", int'(bt_t[1]), 1);
        check("R2 beat after last", int'(bt_t[5]), 0);
        check("R3 no capture before CL", int'(cap_t[2]), 0);
        check("R3 first capture", int'(cap_t[3]), 1);
      end
      if (v == 2) begin
        check("R5 cke still high", int'(cke_t[2]), 1);
        check("R5 cke low next", int'(cke_t[3]), 0);
        check("R6 frozen beat", int'(bt_t[4]), 0);
        check("R7 cke back high", int'(cke_t[6]), 1);
      end
      if (v == 3) begin
        check("R8 blocked after idle", int'(rdy_t[10]), 0);
      end
    end

    // R11: release in the limit cycle itself
    run_burst(0, 1, SMAX);
    check("R11 low cycles", count(2), SMAX);
    check("R11 no flag", int'(flg_t[8]), 0);
    check("R11 ready cycle", first_ready(), 13);

    // R9/R10: request held past the limit
    run_burst(0, 1, 12);
    check("R9 low cycles capped", count(2), SMAX);
    check("R9 forced high", int'(cke_t[8]), 1);
    check("R9 flag raised", int'(flg_t[8]), 1);
    check("R9 request ignored", int'(cke_t[11]), 1);
    check("R9 all captures", count(1), BL);
    check("R10 flag held in burst", int'(flg_t[12]), 1);
    check("R10 flag cleared", int'(flg_t[14]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule